// File: doc/BRIEF.md
# Searchable Pipeline Queue

This block is a small queue between the decode and execute stages of a pipelined processor. Each entry is an instruction template: a two-bit operation kind, a destination register name and a payload of operand bits. The execute side reads the oldest entry and removes it. The decode side adds new entries at the tail. A clear input empties the queue in one cycle, which the execute side uses when a branch redirects the program.

Before it issues an instruction, the decode stage asks the queue whether any pending entry will still write a given source register. The answer comes back on a combinational search port. The search sees the queue as it stands after the current cycle's removal and before the current cycle's insertion. An entry that is leaving this cycle therefore no longer blocks the decoder, and an entry that is only arriving this cycle does not block it yet. For the same reason, a full queue accepts a new entry in any cycle in which its head leaves.

Top module: `sfifo_search`

## Requirements
- R1: After a synchronous reset the queue is empty: `deq_ready` and `find_hit` are low and `enq_ready` is high.
- R2: `enq_ready` is high when fewer than DEPTH entries are held, or when a removal takes place in the same cycle. An insertion is taken on a clock edge only if `enq_valid` and `enq_ready` are both high.
- R3: `deq_ready` is high exactly when at least one entry is held. While it is high, the `first_*` outputs show the oldest entry. A removal takes place when `deq_req` and `deq_ready` are both high.
- R4: `find_hit` is high when a held entry that is not being removed this cycle has operation kind add (code 0) or load (code 2) and a destination equal to `find_reg`.
- R5: Entries of kind branch (code 1) or store (code 3) never raise `find_hit`, whatever their destination field holds.
- R6: The entry that is removed in the current cycle is left out of the search in that cycle.
- R7: An entry inserted in the current cycle is not seen by the search until the following cycle.
- R8: A cycle with `clear` high leaves the queue empty after the clock edge, whatever its earlier contents.
- R9: When `clear` and an insertion occur in the same cycle, the insertion is dropped and the queue is empty afterwards.
- R10: Entries leave in the order they entered, across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Request to insert an entry |
| enq_op | input | 2 | Operation kind of the new entry |
| enq_dst | input | REG_W | Destination register of the new entry |
| enq_pay | input | PAY_W | Payload of the new entry |
| enq_ready | output | 1 | Queue can take an entry this cycle |
| deq_req | input | 1 | Request to remove the oldest entry |
| deq_ready | output | 1 | Queue holds at least one entry |
| first_op | output | 2 | Operation kind of the oldest entry |
| first_dst | output | REG_W | Destination register of the oldest entry |
| first_pay | output | PAY_W | Payload of the oldest entry |
| clear | input | 1 | Empty the queue at this edge |
| find_reg | input | REG_W | Register name to search for |
| find_hit | output | 1 | A remaining writer of `find_reg` exists |

## Verification
On every cycle, the assertions check the following: the per-slot valid flags agree with the occupancy count, the count never exceeds the depth, a hit never appears while the queue is empty, and a clear, with or without a same-cycle insertion, leaves the queue empty. Only the bench's scenarios can show the following: that the search leaves out the departing head and does not yet see the arriving tail, that branch and store entries never match, that a full queue accepts an entry while its head leaves, and that order holds across wrap-around. The bench shows these by comparing the outputs each cycle with a behavioural queue model.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_BRZ   = 2'd1,
        OPC_LOAD  = 2'd2,
        OPC_STORE = 2'd3
    } opc_e;

    // Only kinds that write a register are visible to the search.
    function automatic logic opc_writes_reg(opc_e op);
        return (op == OPC_ADD) || (op == OPC_LOAD);
    endfunction

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_fire,
    input  logic          deq_fire,
    input  logic          clear,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [CW-1:0] count
);

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (deq_fire) head <= bump(head);
            if (enq_fire) tail <= bump(tail);
            case ({enq_fire, deq_fire})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0));

endmodule

// File: rtl/sfifo_slot_match.sv
module sfifo_slot_match #(
    parameter int REG_W = 5
) (
    input  logic             valid,
    input  logic             exclude,
    input  sfifo_pkg::opc_e  op,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] key,
    output logic             hit
);

    always_comb begin
        hit = valid && !exclude && sfifo_pkg::opc_writes_reg(op) && (dst == key);
    end

endmodule

// File: rtl/sfifo_search.sv
module sfifo_search #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5,
    parameter int PAY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  logic [1:0]       enq_op,
    input  logic [REG_W-1:0] enq_dst,
    input  logic [PAY_W-1:0] enq_pay,
    output logic             enq_ready,
    input  logic             deq_req,
    output logic             deq_ready,
    output logic [1:0]       first_op,
    output logic [REG_W-1:0] first_dst,
    output logic [PAY_W-1:0] first_pay,
    input  logic             clear,
    input  logic [REG_W-1:0] find_reg,
    output logic             find_hit
);
    import sfifo_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]    head, tail;
    logic [CW-1:0]    count;
    logic             enq_fire, deq_fire;
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] slot_hit;
    opc_e             op_q  [DEPTH];
    logic [REG_W-1:0] dst_q [DEPTH];
    logic [PAY_W-1:0] pay_q [DEPTH];

    always_comb begin
        deq_ready = (count != '0);
        deq_fire  = deq_req && deq_ready;
        enq_ready = (count != CW'(DEPTH)) || deq_fire;
        enq_fire  = enq_valid && enq_ready && !clear;
    end

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .enq_fire (enq_fire),
        .deq_fire (deq_fire),
        .clear    (clear),
        .head     (head),
        .tail     (tail),
        .count    (count)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            valid_q <= '0;
        end else begin
            if (deq_fire) valid_q[head] <= 1'b0;
            if (enq_fire) valid_q[tail] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (enq_fire) begin
            op_q[tail]  <= opc_e'(enq_op);
            dst_q[tail] <= enq_dst;
            pay_q[tail] <= enq_pay;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        sfifo_slot_match #(.REG_W(REG_W)) u_match (
            .valid   (valid_q[i]),
            .exclude (deq_fire && (head == PW'(i))),
            .op      (op_q[i]),
            .dst     (dst_q[i]),
            .key     (find_reg),
            .hit     (slot_hit[i])
        );
    end

    always_comb begin
        find_hit  = |slot_hit;
        first_op  = op_q[head];
        first_dst = dst_q[head];
        first_pay = pay_q[head];
    end

    // R3
    valid_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_q) == int'(count));

    // R4
    hit_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        find_hit |-> deq_ready);

    // R9
    clear_drops_enq_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && enq_valid) |=> !deq_ready);

endmodule

// File: tb/sfifo_search_bench.sv
module sfifo_search_bench;
    localparam int DEPTH = 4;
    localparam int REG_W = 5;
    localparam int PAY_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enq_valid = 1'b0;
    logic [1:0]       enq_op = '0;
    logic [REG_W-1:0] enq_dst = '0;
    logic [PAY_W-1:0] enq_pay = '0;
    logic             enq_ready;
    logic             deq_req = 1'b0;
    logic             deq_ready;
    logic [1:0]       first_op;
    logic [REG_W-1:0] first_dst;
    logic [PAY_W-1:0] first_pay;
    logic             clear = 1'b0;
    logic [REG_W-1:0] find_reg = '0;
    logic             find_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0]       m_op  [$];
    logic [REG_W-1:0] m_dst [$];
    logic [PAY_W-1:0] m_pay [$];

    always #5 clk = ~clk;

    sfifo_search #(.DEPTH(DEPTH), .REG_W(REG_W), .PAY_W(PAY_W)) u_sfifo_search (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_op(enq_op), .enq_dst(enq_dst), .enq_pay(enq_pay),
        .enq_ready(enq_ready),
        .deq_req(deq_req), .deq_ready(deq_ready),
        .first_op(first_op), .first_dst(first_dst), .first_pay(first_pay),
        .clear(clear), .find_reg(find_reg), .find_hit(find_hit)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare with the model, then advance the model at the edge.
    task automatic cyc(input bit ev, input logic [1:0] op, input int dst, input int pay,
                       input bit dq, input bit clr, input int key, input string tag);
        bit e_dfire, e_eready, e_hit;
        @(negedge clk);
        enq_valid = ev; enq_op = op; enq_dst = REG_W'(dst); enq_pay = PAY_W'(pay);
        deq_req = dq; clear = clr; find_reg = REG_W'(key);
        #1;
        e_dfire  = dq && (m_op.size() > 0);
        e_eready = (m_op.size() < DEPTH) || e_dfire;
        e_hit    = 0;
        for (int k = (e_dfire ? 1 : 0); k < m_op.size(); k++)
            if ((m_op[k] == 2'd0 || m_op[k] == 2'd2) && m_dst[k] == REG_W'(key)) e_hit = 1;
        check("R2", "enq_ready", int'(enq_ready), int'(e_eready));
        check("R3", "deq_ready", int'(deq_ready), int'(m_op.size() > 0));
        check(tag, "find_hit", int'(find_hit), int'(e_hit));
        if (m_op.size() > 0) begin
            check(tag, "first_op",  int'(first_op),  int'(m_op[0]));
            check(tag, "first_dst", int'(first_dst), int'(m_dst[0]));
            check(tag, "first_pay", int'(first_pay), int'(m_pay[0]));
        end
        @(posedge clk);
        if (clr) begin
            m_op.delete(); m_dst.delete(); m_pay.delete();
        end else begin
            if (e_dfire) begin
                void'(m_op.pop_front()); void'(m_dst.pop_front()); void'(m_pay.pop_front());
            end
            if (ev && e_eready) begin
                m_op.push_back(op); m_dst.push_back(REG_W'(dst)); m_pay.push_back(PAY_W'(pay));
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "deq_ready", int'(deq_ready), 0);
        check("R1", "find_hit",  int'(find_hit), 0);
        check("R1", "enq_ready", int'(enq_ready), 1);

        // Fill with adds; each searches for its own, not yet visible, destination.
        for (int i = 1; i <= DEPTH; i++) cyc(1, 2'd0, i, 100 + i, 0, 0, i, "R7");
        cyc(0, 2'd0, 0, 0, 0, 0, DEPTH, "R7");
        cyc(0, 2'd0, 0, 0, 0, 0, 1, "R4");
        // Full, no removal: insertion must be refused.
        cyc(1, 2'd2, 9, 999, 0, 0, 9, "R2");
        // Full with removal: head excluded from search, new entry taken.
        cyc(1, 2'd2, 1, 555, 1, 0, 1, "R6");
        cyc(0, 2'd0, 0, 0, 0, 0, 1, "R7");
        // Clear a full queue.
        cyc(0, 2'd0, 0, 0, 0, 1, 2, "R8");
        cyc(0, 2'd0, 0, 0, 0, 0, 2, "R8");
        // Branch and store never match.
        cyc(1, 2'd1, 7, 11, 0, 0, 7, "R5");
        cyc(1, 2'd3, 8, 12, 0, 0, 7, "R5");
        cyc(0, 2'd0, 0, 0, 0, 0, 7, "R5");
        cyc(0, 2'd0, 0, 0, 0, 0, 8, "R5");
        // Clear together with an insertion.
        cyc(1, 2'd0, 3, 13, 0, 1, 3, "R9");
        cyc(0, 2'd0, 0, 0, 0, 0, 3, "R9");
        // Long random run for ordering across wrap-around.
        for (int n = 0; n < 600; n++)
            cyc(($urandom % 3) != 0, 2'($urandom), int'($urandom % 8), int'($urandom % 65536),
                ($urandom % 2) == 0, ($urandom % 40) == 0, int'($urandom % 8), "R10");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule